// File: doc/BRIEF.md
# Selectable-Order Burst Address Generator

This block sequences the two low address bits of a four-beat memory burst. A load strobe captures an external start address as the first beat. Each advance strobe then moves to the next beat in one of two orders. In the interleaved order, beat n is the start address XOR n. In the linear order, beat n is the start address plus n, wrapping modulo four.

A static order-select input picks the order. The block captures that input at the moment a burst is loaded and uses the captured value for the rest of the burst. While the clock-enable input is low, the block ignores every strobe and holds its output, so an enclosing memory controller can insert wait states.

The upper address bits, the storage array and the command decoding are left to the surrounding logic. The output is driven from registered state, so it changes only on a clock edge.

Top module: `burst_addr_gen`

## Requirements
- R1: While reset is asserted, and after it is released with no strobe, `beat_addr` is 2'b00, the captured order is interleaved and the beat index is 0.
- R2: A clock edge with `clk_en`=1 and `load`=1 makes `beat_addr` equal to the `start_addr` present at that edge.
- R3: With the captured order interleaved (`order_il`=1 at load), the k-th advance after a load gives start XOR k. For example, start 01 yields 01,00,11,10.
- R4: With the captured order linear (`order_il`=0 at load), the k-th advance after a load gives (start + k) mod 4. For example, start 11 yields 11,00,01,10.
- R5: The fourth advance after a load returns `beat_addr` to the start address, and the same sequence then repeats.
- R6: On an edge with `clk_en`=0, `beat_addr` and all internal state are unchanged, whatever `load`, `advance`, `order_il` and `start_addr` are.
- R7: `order_il` is captured only on a load edge. Changing it during a burst does not alter the order until the next load.
- R8: When `load` and `advance` are both high on an enabled edge, the load wins and `beat_addr` becomes `start_addr`.
- R9: An enabled edge with neither `load` nor `advance` leaves `beat_addr` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_en | input | 1 | Clock enable; low stalls the block |
| load | input | 1 | Begin a burst at `start_addr` |
| advance | input | 1 | Step to the next beat |
| order_il | input | 1 | Order select: 1 interleaved, 0 linear |
| start_addr | input | 2 | First-beat address |
| beat_addr | output | 2 | Current burst address bits |

## Verification
The bench runs full four-beat bursts from several start addresses in both orders. Starts 01 and 11 are the ones that tell the two orders apart; from 00 and 10 the orders produce the same sequence, so those starts check the XOR/add arithmetic but do not prove which order was selected. A fifth advance checks the wrap back to the start address. Stalled edges that carry loads and advances must leave the output unchanged. A flip of `order_il` in mid-burst, from a start where the two orders diverge, shows whether the order was captured at load time. A simultaneous load and advance resolves the priority between them. An asynchronous reset in mid-burst checks the return to the reset state.

// File: rtl/burst_addr_pkg.sv
package burst_addr_pkg;

    typedef enum logic {
        ORD_LINEAR = 1'b0,
        ORD_INTERLEAVE = 1'b1
    } burst_order_e;

endpackage

// File: rtl/burst_beat_ctrl.sv
module burst_beat_ctrl
    import burst_addr_pkg::*;
#(
    parameter int BEAT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clk_en,
    input  logic              load,
    input  logic              advance,
    input  logic              order_il,
    input  logic [BEAT_W-1:0] start_addr,
    output logic [BEAT_W-1:0] base_q_o,
    output logic [BEAT_W-1:0] idx_q_o,
    output burst_order_e      order_q_o
);

    localparam logic [BEAT_W-1:0] IDX_ONE = BEAT_W'(1);

    typedef struct packed {
        logic [BEAT_W-1:0] base;
        logic [BEAT_W-1:0] idx;
        burst_order_e      order;
    } ctrl_state_t;

    ctrl_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clk_en) begin
            if (load) begin
                st_d.base  = start_addr;
                st_d.idx   = '0;
                st_d.order = order_il ? ORD_INTERLEAVE : ORD_LINEAR;
            end else if (advance) begin
                st_d.idx = st_q.idx + IDX_ONE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.base  <= '0;
            st_q.idx   <= '0;
            st_q.order <= ORD_INTERLEAVE;
        end else begin
            st_q <= st_d;
        end
    end

    assign base_q_o  = st_q.base;
    assign idx_q_o   = st_q.idx;
    assign order_q_o = st_q.order;

    AST_ADV_STEPS_IDX: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && !load && advance) |=> (idx_q_o == $past(idx_q_o) + IDX_ONE)); // R5
    AST_LOAD_CLEARS_IDX: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && load) |=> (idx_q_o == '0)); // R2
    AST_ORDER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !(clk_en && load) |=> $stable(order_q_o)); // R7
    AST_STALL_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_en |=> ($stable(idx_q_o) && $stable(base_q_o))); // R6

endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
    import burst_addr_pkg::*;
#(
    parameter int BEAT_W = 2
) (
    input  logic [BEAT_W-1:0] base,
    input  logic [BEAT_W-1:0] idx,
    input  burst_order_e      order,
    output logic [BEAT_W-1:0] addr
);

    logic [BEAT_W-1:0] il_addr;
    logic [BEAT_W-1:0] lin_addr;

    genvar b;
    generate
        for (b = 0; b < BEAT_W; b++) begin : g_xor_bit
            assign il_addr[b] = base[b] ^ idx[b];
        end
    endgenerate

    assign lin_addr = base + idx;

    always_comb begin
        addr = (order == ORD_INTERLEAVE) ? il_addr : lin_addr;
    end

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
    import burst_addr_pkg::*;
#(
    parameter int BEAT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clk_en,
    input  logic              load,
    input  logic              advance,
    input  logic              order_il,
    input  logic [BEAT_W-1:0] start_addr,
    output logic [BEAT_W-1:0] beat_addr
);

    logic [BEAT_W-1:0] base_q;
    logic [BEAT_W-1:0] idx_q;
    burst_order_e      order_q;

    burst_beat_ctrl #(.BEAT_W(BEAT_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .clk_en     (clk_en),
        .load       (load),
        .advance    (advance),
        .order_il   (order_il),
        .start_addr (start_addr),
        .base_q_o   (base_q),
        .idx_q_o    (idx_q),
        .order_q_o  (order_q)
    );

    burst_order_map #(.BEAT_W(BEAT_W)) u_map (
        .base  (base_q),
        .idx   (idx_q),
        .order (order_q),
        .addr  (beat_addr)
    );

    AST_LOAD_TAKES_START: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && load) |=> (beat_addr == $past(start_addr))); // R2
    AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_en |=> $stable(beat_addr)); // R6
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && !load && !advance) |=> $stable(beat_addr)); // R9
    AST_RESET_ZERO: assert property (@(posedge clk)
        !rst_n |-> (beat_addr == '0)); // R1

endmodule

// File: tb/burst_addr_gen_bench.sv
module burst_addr_gen_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       clk_en = 1'b0;
    logic       load = 1'b0;
    logic       advance = 1'b0;
    logic       order_il = 1'b0;
    logic [1:0] start_addr = 2'b00;
    logic [1:0] beat_addr;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    burst_addr_gen u_burst_addr_gen (
        .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .load(load),
        .advance(advance), .order_il(order_il), .start_addr(start_addr),
        .beat_addr(beat_addr)
    );

    // vector: {load, advance, clk_en, order_il, start[1:0], expected[1:0]}
    localparam int NV = 29;
    localparam logic [7:0] VEC [NV] = '{
        8'b1_0_1_1_01_01, // R2 load 01 interleaved
        8'b0_1_1_0_00_00, // R3
        8'b0_1_1_0_00_11, // R3
        8'b0_1_1_0_00_10, // R3
        8'b0_1_1_0_00_01, // R5 wrap
        8'b1_0_1_0_11_11, // R2 load 11 linear
        8'b0_1_1_1_00_00, // R4
        8'b0_1_1_1_00_01, // R4
        8'b0_1_1_1_00_10, // R4
        8'b0_1_1_1_00_11, // R5 wrap
        8'b0_1_0_1_00_11, // R6 stalled advance
        8'b1_0_0_1_01_11, // R6 stalled load
        8'b0_0_1_1_00_11, // R9 idle
        8'b0_1_1_1_00_00, // R7 mode flipped, still linear
        8'b0_1_1_1_00_01, // R7
        8'b1_1_1_1_11_11, // R8 load beats advance
        8'b0_1_1_0_00_10, // R7 interleaved kept
        8'b1_0_1_1_00_00, // R2 load 00 interleaved
        8'b0_1_1_1_00_01, // R3
        8'b0_1_1_1_00_10, // R3
        8'b0_1_1_1_00_11, // R3
        8'b1_0_1_1_10_10, // R2 load 10 interleaved
        8'b0_1_1_1_00_11, // R3
        8'b0_1_1_1_00_00, // R3
        8'b0_1_1_1_00_01, // R3
        8'b1_0_1_0_01_01, // R2 load 01 linear
        8'b0_1_1_0_00_10, // R4
        8'b0_1_1_0_00_11, // R4
        8'b0_1_1_0_00_00  // R4
    };
    localparam int VREQ [NV] = '{2,3,3,3,5,2,4,4,4,5,6,6,9,7,7,8,7,2,3,3,3,2,3,3,3,2,4,4,4};

    task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: beat_addr actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic step(input logic ld, input logic adv, input logic en,
                        input logic md, input logic [1:0] st);
        load = ld; advance = adv; clk_en = en; order_il = md; start_addr = st;
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1", beat_addr, 2'b00);        // during reset
        rst_n = 1'b1;
        step(1'b0, 1'b0, 1'b1, 1'b0, 2'b11);
        check("R1", beat_addr, 2'b00);        // after release, idle

        for (int i = 0; i < NV; i++) begin
            step(VEC[i][7], VEC[i][6], VEC[i][5], VEC[i][4], VEC[i][3:2]);
            check($sformatf("R%0d vec%0d", VREQ[i], i), beat_addr, VEC[i][1:0]);
        end

        // R1: reset mid-burst, then reset-state order is interleaved from 00
        step(1'b1, 1'b0, 1'b1, 1'b0, 2'b11);
        step(1'b0, 1'b1, 1'b1, 1'b0, 2'b00);
        check("R4", beat_addr, 2'b00);
        rst_n = 1'b0;
        #1;
        check("R1", beat_addr, 2'b00);
        @(negedge clk);
        rst_n = 1'b1;
        step(1'b0, 1'b1, 1'b1, 1'b0, 2'b10);
        check("R1", beat_addr, 2'b01);
        step(1'b0, 1'b1, 1'b1, 1'b0, 2'b10);
        check("R1", beat_addr, 2'b10);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule